// File: doc/BRIEF.md
# Armed Monitor Capture Controller

This block is the central spy point for monitor data. Software arms it once, and at the next L1 accept it freezes a single snapshot of three monitor source groups: a group of scaler terms, a second scaler group, and the front-end busy states. It then disarms itself. Software may also force a snapshot when no accepts are arriving, for example during a quiet run.

Each source group has a different fixed latency to the point of capture. Each group therefore passes through its own fixed-depth history line, clocked by the beam-crossing clock. The depths are chosen so that every value in a snapshot belongs to the crossing that caused the accept. The first scaler group runs one stage deeper than the second. Because only history taps feed the snapshot registers, the newest crossing is never captured.

An arm request cannot race an accept, because it takes effect only while the bunch-gap indicator is high. A request made outside a gap waits as pending until the next gap cycle. The snapshot registers and the done flag stay unchanged until an arm takes effect, and that arm clears them.

Top module: `mon_capture_ctrl`

## Requirements
- R1: When armed_o is 1 and l1_accept_i is 1 at a clock edge, the snapshot outputs take the history taps after that edge, done_o becomes 1 and armed_o becomes 0.
- R2: An l1_accept_i while armed_o is 0 leaves the snapshot outputs and done_o unchanged.
- R3: force_i at an edge captures the same taps as an accept, whether or not the block is armed. It also sets done_o and clears armed_o.
- R4: An arm request (arm_i, or a pending request) takes effect only at an edge where gap_i is 1, and sets armed_o from the next cycle. A request at an edge with gap_i 0 sets pending_o, which holds until the request takes effect.
- R5: When an arm takes effect, all snapshot outputs become 0 and done_o becomes 0.
- R6: A capture at edge n stores scal_a_i from edge n-(HIST_DEPTH+1), scal_b_i from edge n-HIST_DEPTH and busy_i from edge n-BUSY_DEPTH. Taps that reach back before reset release read as 0, so the current crossing is never stored.
- R7: If a capture (R1 or R3) and an arm request fall on the same edge, the capture wins. armed_o becomes 0 and the request stays pending (pending_o 1).
- R8: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Beam-crossing clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| l1_accept_i | input | 1 | L1 accept strobe |
| gap_i | input | 1 | High during an accelerator bunch gap |
| arm_i | input | 1 | Host arm request strobe |
| force_i | input | 1 | Host forced-capture strobe |
| scal_a_i | input | A_W | Scaler group A word (deeper history) |
| scal_b_i | input | B_W | Scaler group B word |
| busy_i | input | BUSY_W | Front-end busy states |
| snap_a_o | output | A_W | Captured group A |
| snap_b_o | output | B_W | Captured group B |
| snap_busy_o | output | BUSY_W | Captured busy states |
| armed_o | output | 1 | Armed, waiting for an accept |
| pending_o | output | 1 | Arm request waiting for a gap |
| done_o | output | 1 | Snapshot captured since last arm |

## Verification
A capture, from an armed accept or a force, can fall on the same edge as an arm request that a gap would otherwise let take effect. A directed step drives force_i, arm_i and gap_i together. Random steps also mix these strobes freely with gaps and accepts. A bench reference model judges the result: it gives the capture priority, keeps the request pending, and compares the snapshot with the history taps it recorded itself.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
  typedef enum logic [1:0] {
    ACT_NONE    = 2'd0,
    ACT_CAPTURE = 2'd1,
    ACT_ARM     = 2'd2
  } mcc_act_e;
endpackage

// File: rtl/mcc_hist_line.sv
module mcc_hist_line #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] tap_o
);
  logic [W-1:0] sr_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(DEPTH); i++) sr_q[i] <= '0;
    end else begin
      sr_q[0] <= d_i;
      for (int i = 1; i < int'(DEPTH); i++) sr_q[i] <= sr_q[i-1];
    end
  end

  assign tap_o = sr_q[DEPTH-1];
endmodule

// File: rtl/mcc_arm_ctrl.sv
module mcc_arm_ctrl
  import mcc_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     l1_accept_i,
  input  logic     gap_i,
  input  logic     arm_i,
  input  logic     force_i,
  output mcc_act_e act_o,
  output logic     armed_o,
  output logic     pending_o
);
  logic armed_q, pend_q, req;

  assign req = arm_i | pend_q;

  always_comb begin
    if (force_i || (armed_q && l1_accept_i)) act_o = ACT_CAPTURE;
    else if (req && gap_i)                   act_o = ACT_ARM;
    else                                     act_o = ACT_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      unique case (act_o)
        ACT_CAPTURE: begin armed_q <= 1'b0; pend_q <= req;  end
        ACT_ARM:     begin armed_q <= 1'b1; pend_q <= 1'b0; end
        default:     pend_q <= req;
      endcase
    end
  end

  assign armed_o   = armed_q;
  assign pending_o = pend_q;

  // arming only ever starts from a gap cycle
  assert_arm_in_gap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_q) |-> $past(gap_i));

  // capture beats a simultaneous arm; request is kept
  assert_capture_priority_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((force_i || (armed_q && l1_accept_i)) && req) |=> (pend_q && !armed_q));
endmodule

// File: rtl/mon_capture_ctrl.sv
module mon_capture_ctrl
  import mcc_pkg::*;
#(
  parameter int unsigned A_W        = 16,
  parameter int unsigned B_W        = 12,
  parameter int unsigned BUSY_W     = 8,
  parameter int unsigned HIST_DEPTH = 3,
  parameter int unsigned BUSY_DEPTH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              l1_accept_i,
  input  logic              gap_i,
  input  logic              arm_i,
  input  logic              force_i,
  input  logic [A_W-1:0]    scal_a_i,
  input  logic [B_W-1:0]    scal_b_i,
  input  logic [BUSY_W-1:0] busy_i,
  output logic [A_W-1:0]    snap_a_o,
  output logic [B_W-1:0]    snap_b_o,
  output logic [BUSY_W-1:0] snap_busy_o,
  output logic              armed_o,
  output logic              pending_o,
  output logic              done_o
);
  localparam int unsigned A_DEPTH = HIST_DEPTH + 1;

  logic [A_W-1:0]    tap_a;
  logic [B_W-1:0]    tap_b;
  logic [BUSY_W-1:0] tap_busy;
  mcc_act_e          act;

  mcc_hist_line #(.W(A_W), .DEPTH(A_DEPTH)) u_hist_a (
    .clk_i, .rst_ni, .d_i(scal_a_i), .tap_o(tap_a));
  mcc_hist_line #(.W(B_W), .DEPTH(HIST_DEPTH)) u_hist_b (
    .clk_i, .rst_ni, .d_i(scal_b_i), .tap_o(tap_b));
  mcc_hist_line #(.W(BUSY_W), .DEPTH(BUSY_DEPTH)) u_hist_busy (
    .clk_i, .rst_ni, .d_i(busy_i), .tap_o(tap_busy));

  mcc_arm_ctrl u_ctrl (
    .clk_i, .rst_ni, .l1_accept_i, .gap_i, .arm_i, .force_i,
    .act_o(act), .armed_o, .pending_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_a_o    <= '0;
      snap_b_o    <= '0;
      snap_busy_o <= '0;
      done_o      <= 1'b0;
    end else begin
      unique case (act)
        ACT_CAPTURE: begin
          snap_a_o    <= tap_a;
          snap_b_o    <= tap_b;
          snap_busy_o <= tap_busy;
          done_o      <= 1'b1;
        end
        ACT_ARM: begin
          snap_a_o    <= '0;
          snap_b_o    <= '0;
          snap_busy_o <= '0;
          done_o      <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assert_accept_capture_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_o && l1_accept_i) |=> (done_o && !armed_o));

  assert_idle_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_o && !force_i && !(gap_i && (arm_i || pending_o)))
      |=> ($stable(snap_a_o) && $stable(snap_b_o) && $stable(snap_busy_o) && $stable(done_o)));

  assert_force_capture_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_i |=> (done_o && !armed_o));

  assert_arm_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gap_i && (arm_i || pending_o) && !force_i && !(armed_o && l1_accept_i))
      |=> (armed_o && !done_o && snap_a_o == '0 && snap_busy_o == '0));
endmodule

// File: tb/sim_mon_capture_ctrl.sv
module sim_mon_capture_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int A_W = 16, B_W = 12, BUSY_W = 8, HD = 3, BD = 2;
  localparam int NMAX = 4096;

  logic clk = 1'b0, rst_n = 1'b0;
  logic l1 = 0, gap = 0, arm = 0, frc = 0;
  logic [A_W-1:0] sa = '0;
  logic [B_W-1:0] sb = '0;
  logic [BUSY_W-1:0] sbusy = '0;
  logic [A_W-1:0] oa;
  logic [B_W-1:0] ob;
  logic [BUSY_W-1:0] obusy;
  logic o_armed, o_pend, o_done;

  always #(CLK_PERIOD/2) clk = ~clk;

  mon_capture_ctrl #(.A_W(A_W), .B_W(B_W), .BUSY_W(BUSY_W),
                     .HIST_DEPTH(HD), .BUSY_DEPTH(BD)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .l1_accept_i(l1), .gap_i(gap),
    .arm_i(arm), .force_i(frc), .scal_a_i(sa), .scal_b_i(sb), .busy_i(sbusy),
    .snap_a_o(oa), .snap_b_o(ob), .snap_busy_o(obusy),
    .armed_o(o_armed), .pending_o(o_pend), .done_o(o_done));

  int checks = 0, fails = 0, n = 0;
  bit finished = 0;
  logic [A_W-1:0] ha [NMAX];
  logic [B_W-1:0] hb [NMAX];
  logic [BUSY_W-1:0] hbusy [NMAX];
  logic m_armed = 0, m_pend = 0, m_done = 0;
  logic [A_W-1:0] m_a = '0;
  logic [B_W-1:0] m_b = '0;
  logic [BUSY_W-1:0] m_busy = '0;

  function automatic logic [A_W-1:0] tap_a(int k);
    return (k - (HD + 1) >= 0) ? ha[k-(HD+1)] : '0;
  endfunction
  function automatic logic [B_W-1:0] tap_b(int k);
    return (k - HD >= 0) ? hb[k-HD] : '0;
  endfunction
  function automatic logic [BUSY_W-1:0] tap_busy(int k);
    return (k - BD >= 0) ? hbusy[k-BD] : '0;
  endfunction

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h (step %0d)", tag, what, act, exp, n);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, "armed", o_armed, m_armed);
    chk(tag, "pending", o_pend, m_pend);
    chk(tag, "done", o_done, m_done);
    chk(tag, "snap_a", oa, m_a);
    chk(tag, "snap_b", ob, m_b);
    chk(tag, "snap_busy", obusy, m_busy);
  endtask

  // called at negedge: drive, model the coming edge, check after it
  task automatic step(bit a, bit f, bit l, bit g, string tag);
    logic req;
    arm = a; frc = f; l1 = l; gap = g;
    sa = A_W'($urandom); sb = B_W'($urandom); sbusy = BUSY_W'($urandom);
    ha[n] = sa; hb[n] = sb; hbusy[n] = sbusy;
    req = a | m_pend;
    if (f || (m_armed && l)) begin
      m_armed = 0; m_pend = req; m_done = 1;
      m_a = tap_a(n); m_b = tap_b(n); m_busy = tap_busy(n);
    end else if (req && g) begin
      m_armed = 1; m_pend = 0; m_done = 0;
      m_a = '0; m_b = '0; m_busy = '0;
    end else begin
      m_pend = req;
    end
    @(negedge clk);
    n++;
    check_all(tag);
  endtask

  initial begin
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all("R8");
    step(0, 0, 1, 0, "R2");
    step(0, 0, 0, 0, "R2");
    step(1, 0, 0, 0, "R4");
    step(0, 0, 1, 0, "R4");
    step(0, 0, 0, 1, "R4");
    step(0, 0, 0, 0, "R1");
    step(0, 0, 1, 0, "R1");
    step(0, 0, 1, 0, "R2");
    step(1, 0, 0, 1, "R5");
    step(1, 1, 0, 1, "R7");
    step(0, 0, 0, 0, "R7");
    step(0, 0, 0, 1, "R7");
    step(0, 0, 1, 1, "R7");
    step(0, 1, 0, 0, "R3");
    step(0, 1, 0, 0, "R3");
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 12) == 0, ($urandom % 25) == 0,
           ($urandom % 6) == 0, ($urandom % 4) == 0, "R6");
    end
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired at step %0d", n);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule